// File: doc/BRIEF.md
# Burst Split-and-Reissue Controller

This controller carries one requested burst (a start address and a beat count) onto a destination bus. On that bus a transaction may not pause once its data has started. A transaction may hold off only during its address phase, before the first beat. Once data is flowing, every cycle must either move a beat or end the transaction.

The source side reports how many beats it holds ready. When that count drops to zero in the middle of a transaction, the controller ends the transaction on that same cycle and does not stall. It then issues a fresh transaction at the next address, carrying the remaining count. Every transaction is also capped at a parameterised maximum burst length. As a result, one request can leave the block as several transactions, split by data gaps, by the cap, or by both. Those transactions together move exactly the requested number of beats over one contiguous address range.

Top module: `burst_reissue_ctrl`

## Requirements
- R1: While reset is held and after its release, busy, txn_start, beat, txn_term, done and data_phase are all 0.
- R2: A request is taken only while busy is 0 and req_valid is 1. A req_valid seen while busy is 1 has no effect on any output.
- R3: txn_start is high for exactly one cycle, the first address-phase cycle of each transaction. In that cycle txn_len equals the smaller of the beats still owed and MAX_BURST, and is never 0.
- R4: In the address phase, a cycle with avail equal to 0 is a wait state: no beat, no txn_term, and the address phase continues.
- R5: In the address or data phase, beat is 1 in every cycle where avail is nonzero. A data-phase cycle without a beat always carries txn_term.
- R6: txn_term is 1 for one cycle when either of two things happens: the last beat of the transaction is moved (txn_term and beat in the same cycle), or avail is 0 during the data phase (txn_term with no beat).
- R7: If beats are still owed after a termination, a new txn_start follows exactly two cycles after txn_term. Its txn_addr is the request address plus BEAT_BYTES times the beats already moved.
- R8: done pulses for one cycle, two cycles after the final txn_term. For a zero-length request, done pulses one cycle after acceptance and no transaction is issued. busy returns to 0 in the cycle after done.
- R9: The beats moved for one request add up to exactly req_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Byte address of the first beat |
| req_len | input | LEN_W | Number of beats requested |
| avail | input | CNT_W | Beats the source side holds ready |
| busy | output | 1 | A request is in progress |
| txn_start | output | 1 | First cycle of a transaction's address phase |
| txn_addr | output | ADDR_W | Transaction start address, valid with txn_start |
| txn_len | output | LEN_W | Transaction beat count, valid with txn_start |
| beat | output | 1 | One beat moves this cycle |
| txn_term | output | 1 | The current transaction ends this cycle |
| data_phase | output | 1 | The transaction is past its first beat |
| done | output | 1 | Request finished |

## Verification
With the source always full, the only splits come from the MAX_BURST cap. This shows the length cap and the reissue spacing without any gap-driven terminations. A long starvation at the start of a request keeps the address phase in wait states, which shows that waiting is allowed before the first beat and nowhere else. Random data gaps force mid-burst terminations at arbitrary beat counts, so the continuation address and remaining length are checked across many splits. Zero-length, single-beat and exact-cap requests, together with a request strobe held high while busy, cover the edges of the acceptance and splitting logic.

// File: rtl/burst_reissue_ctrl.sv
module burst_reissue_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int CNT_W      = 6,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_BURST  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [CNT_W-1:0]  avail,
  output logic              busy,
  output logic              txn_start,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [LEN_W-1:0]  txn_len,
  output logic              beat,
  output logic              txn_term,
  output logic              data_phase,
  output logic              done
);

  localparam logic [LEN_W-1:0]  CAP  = LEN_W'(MAX_BURST);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_TERM, S_DONE} state_t;

  state_t            state, nxt;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remaining;
  logic [LEN_W-1:0]  txn_left;
  logic              issued;

  function automatic logic [LEN_W-1:0] cap_len(input logic [LEN_W-1:0] n);
    return (n > CAP) ? CAP : n;
  endfunction

  wire has_data = (avail != '0);
  wire in_txn   = (state == S_ADDR) || (state == S_DATA);
  wire accept   = (state == S_IDLE) && req_valid;

  assign busy       = (state != S_IDLE);
  assign data_phase = (state == S_DATA);
  assign done       = (state == S_DONE);
  assign txn_start  = (state == S_ADDR) && !issued;
  assign txn_addr   = cur_addr;
  assign txn_len    = txn_left;
  assign beat       = in_txn && has_data;
  assign txn_term   = (beat && txn_left == LEN_W'(1)) || (data_phase && !has_data);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (req_valid) nxt = (req_len == '0) ? S_DONE : S_ADDR;
      S_ADDR: if (has_data) nxt = txn_term ? S_TERM : S_DATA;
      S_DATA: if (txn_term) nxt = S_TERM;
      S_TERM: nxt = (remaining == '0) ? S_DONE : S_ADDR;
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      remaining <= '0;
      txn_left  <= '0;
      issued    <= 1'b0;
    end else begin
      state  <= nxt;
      issued <= (state == S_ADDR) && (nxt == S_ADDR);
      if (accept) begin
        cur_addr  <= req_addr;
        remaining <= req_len;
        txn_left  <= cap_len(req_len);
      end else if (beat) begin
        cur_addr  <= cur_addr + STEP;
        remaining <= remaining - LEN_W'(1);
        txn_left  <= txn_left - LEN_W'(1);
      end else if (state == S_TERM) begin
        txn_left  <= cap_len(remaining);
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(beat || txn_term || txn_start || data_phase)); // R1

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> (txn_len != '0 && txn_len <= CAP)); // R3

  AST_WAIT_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_txn && !data_phase && !has_data) |=> (state == S_ADDR && !txn_start)); // R4

  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !beat) |-> txn_term); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !txn_term) |=> (cur_addr == $past(cur_addr) + STEP)); // R7

  AST_REISSUE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_term && remaining != LEN_W'(1)) |=> ##1 txn_start); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R8

endmodule

// File: tb/sim_burst_reissue_ctrl.sv
module sim_burst_reissue_ctrl;
  localparam int AW = 32, LW = 12, CW = 6, BB = 4, MB = 8;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [CW-1:0] avail = '0;
  logic busy, txn_start, beat, txn_term, data_phase, done;
  logic [AW-1:0] txn_addr;
  logic [LW-1:0] txn_len;

  burst_reissue_ctrl #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW), .BEAT_BYTES(BB), .MAX_BURST(MB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .avail(avail), .busy(busy), .txn_start(txn_start), .txn_addr(txn_addr), .txn_len(txn_len),
    .beat(beat), .txn_term(txn_term), .data_phase(data_phase), .done(done));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  // model: 0 idle, 1 address phase, 2 data phase, 3 turnaround, 4 finished
  int m_mode = 0, m_rem = 0, m_tl = 0, m_started = 0;
  longint m_addr = 0, r_addr = 0;
  int r_len = 0, moved = 0, fifo = 0, gap_mode = 0, starve = 0;
  bit got_done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
    end
  endtask

  function automatic int mincap(input int n);
    return (n > MB) ? MB : n;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (starve > 0) starve--;
      else if (gap_mode == 0) fifo = fifo + 4;
      else if ($urandom_range(0, 9) < 3) fifo = fifo + $urandom_range(1, 2);
      if (fifo > FULL) fifo = FULL;
    end
    avail = CW'(fifo);
    #1;
    if (!rst_n) begin
      chk(!busy && !txn_start && !beat && !txn_term && !done && !data_phase, "R1", busy, 0);
    end else begin : step
      bit e_beat, e_term, e_start;
      string bt;
      e_beat  = (m_mode == 1 || m_mode == 2) && fifo > 0;
      e_start = (m_mode == 1) && !m_started;
      e_term  = (e_beat && m_tl == 1) || (m_mode == 2 && fifo == 0);
      bt = (m_mode == 1 && fifo == 0) ? "R4" : "R5";
      chk(busy == (m_mode != 0), "R2", busy, m_mode != 0);
      chk(beat == e_beat, bt, beat, e_beat);
      chk(txn_start == e_start, "R3", txn_start, e_start);
      chk(txn_term == e_term, (m_mode == 1 && fifo == 0) ? "R4" : "R6", txn_term, e_term);
      chk(data_phase == (m_mode == 2), "R5", data_phase, m_mode == 2);
      chk(done == (m_mode == 4), "R8", done, m_mode == 4);
      if (e_start) begin
        chk(txn_len == LW'(mincap(m_rem)), "R3", txn_len, mincap(m_rem));
        chk(txn_addr == AW'(r_addr + BB * moved), "R7", txn_addr, r_addr + BB * moved);
      end
      if (m_mode == 4) begin
        chk(moved == r_len, "R9", moved, r_len);
        got_done = 1;
      end
      case (m_mode)
        0: if (req_valid) begin
             r_addr = req_addr; r_len = req_len; moved = 0; fifo = 0;
             m_addr = req_addr; m_rem = req_len; m_tl = mincap(req_len); m_started = 0;
             m_mode = (req_len == 0) ? 4 : 1;
           end
        1: begin
             if (e_beat) m_mode = e_term ? 3 : 2;
             else m_started = 1;
           end
        2: if (e_term) m_mode = 3;
        3: begin
             m_mode = (m_rem == 0) ? 4 : 1;
             m_tl = mincap(m_rem); m_started = 0;
           end
        4: m_mode = 0;
        default: m_mode = 0;
      endcase
      if (e_beat) begin
        fifo--; moved++; m_rem--; m_tl--; m_addr = m_addr + BB;
        if (m_mode != 2 && m_mode != 3) m_started = 0;
      end
      if (m_mode == 2 || m_mode == 3) m_started = 0;
    end
  end

  task automatic run_req(input longint a, input int n, input int mode, input int st, input bit poke);
    @(negedge clk);
    gap_mode = mode; starve = st; got_done = 0;
    req_valid = 1; req_addr = AW'(a); req_len = LW'(n);
    @(negedge clk);
    if (poke) begin
      req_addr = AW'(a + 'h1000); req_len = LW'(3);
      repeat (3) @(negedge clk);
    end
    req_valid = 0;
    while (!got_done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    run_req('h100, 20, 0, 0, 0);      // cap-only splits
    run_req('h2000, 0, 0, 0, 0);      // zero length
    run_req('h3000, 1, 0, 0, 0);      // single beat
    run_req('h4000, MB, 0, 0, 0);     // exact cap
    run_req('h5000, 13, 0, 12, 0);    // long wait states
    run_req('h6000, 37, 1, 0, 1);     // gaps, strobe held while busy
    for (int k = 0; k < 20; k++)
      run_req(longint'($urandom_range(0, 'hFFFF)) * 4, $urandom_range(1, 60), 1, $urandom_range(0, 5), 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule